// File: doc/BRIEF.md
# Master/Slave Reference Selection Controller

This block is the control state machine of a redundant timing module that can act either as the master or as a slave unit. In master mode it chooses one of six local timing references. The choice comes from a programmable priority table or from a manual setting. The input coming from the partner unit is observed, but it never changes that choice.

In slave mode the block steers the loop onto the master's input and widens the loop bandwidth so the slave closely follows the master. It keeps following a drifting master until the measured offset leaves a ±125 ppm hold-in window. When the master is lost or drifts out of that window, the block falls back to local selection. It returns to the master only after the master's input has stayed present and in range for a full soak interval.

While in slave mode the indicator pins are masked, and the alarm and lock outputs take fixed levels. The true operating mode can always be read from a status word. Phase detection, loop filtering and frequency measurement sit outside this block.

Top module: `msref_ctrl`

## Requirements
- R1: After reset: `ref_sel_o` = 7 (none), `status_o` = 8'h3E, `free_run_o` = 1, `alarm_o` = 1, `lock_o` = 0, `wide_bw_o` = 0, `ref_ind_o` = 0.
- R2: In master mode, one clock after the inputs settle, `ref_sel_o` holds the reference at the lowest rank k whose entry `prio_tbl_i[3k+2:3k]` is below 6 and is qualified. `mst_present_i` and `mst_offset_i` have no effect on the selection in this mode.
- R3: With `manual_en_i` = 1, the selected reference is `manual_sel_i` when that reference is qualified. Otherwise no reference is selected and the priority table is ignored.
- R4: When no reference can be selected, the state becomes holdover if `lock_det_i` was seen high while on a local reference or on the master since reset. Otherwise the state becomes free run. In both cases `ref_sel_o` = 7.
- R5: Entering slave mode with the master present and in range selects the master (`ref_sel_o` = 6) one clock later, and sets `wide_bw_o` = 1 while tracking.
- R6: While tracking, the block stays on the master as long as `mst_present_i` = 1 and |`mst_offset_i`| ≤ 125 ppm. It leaves on the next clock when the master is absent or the offset magnitude exceeds 125.
- R7: After a fallback in slave mode, the block returns to the master on the clock edge of the SOAK_TICKS-th consecutive `tick_i` pulse during which the master is present and in range. Any cycle out of range restarts the count.
- R8: In slave mode, `ref_ind_o`, `free_run_o` and `holdover_o` are all 0.
- R9: In slave mode, while tracking, `alarm_o` = 0 and `lock_o` follows `lock_det_i`. In any other slave state, both outputs are 1.
- R10: In master mode, `ref_ind_o` is one-hot on the selected reference in the local state, `holdover_o` and `free_run_o` reflect their states, `alarm_o` = 1 outside the local state, and `lock_o` = `lock_det_i` only in the local state.
- R11: `status_o` has bit 0 = 1 for slave, bits 2:1 = state (0 tracking master, 1 local reference, 2 holdover, 3 free run), bits 5:3 = `ref_sel_o`, and bits 7:6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 1 selects slave operation |
| tick_i | input | 1 | Soak time base pulse |
| mst_present_i | input | 1 | Master input present |
| mst_offset_i | input | 12 | Signed master frequency offset in ppm |
| ref_qual_i | input | 6 | Per-reference qualification flags |
| prio_tbl_i | input | 18 | Rank k reference index in bits [3k+2:3k], rank 0 highest |
| manual_en_i | input | 1 | Manual selection mode |
| manual_sel_i | input | 3 | Manually chosen reference |
| lock_det_i | input | 1 | Loop lock detector |
| ref_sel_o | output | 3 | Chosen source: 0-5 local, 6 master, 7 none |
| wide_bw_o | output | 1 | Wide loop bandwidth select |
| ref_ind_o | output | 6 | Reference indicators |
| free_run_o | output | 1 | Free run indicator |
| holdover_o | output | 1 | Holdover indicator |
| alarm_o | output | 1 | Alarm |
| lock_o | output | 1 | Lock indicator |
| status_o | output | 8 | Mode, state and selection status word |

## Verification
The hardest situation to reach from the ports is a return to the master that was interrupted part way through the soak interval. It needs a slave that is already tracking, a forced fallback through an offset beyond the hold-in limit, and a partial soak. The master-present flag then drops for exactly one cycle, and the bench watches that the return is delayed by the full interval counted from the restart. The soak length is shortened by a parameter, so the exact return edge is checked both one cycle before and on the cycle itself. The hold-in edge is probed at +125, -125 and +126 ppm.

// File: rtl/msref_pkg.sv
package msref_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_LOCAL = 2'd1,
    ST_HOLD  = 2'd2,
    ST_FREE  = 2'd3
  } msref_state_e;
endpackage

// File: rtl/msref_prio_pick.sv
module msref_prio_pick #(
  parameter int NUM_REFS = 6,
  parameter int IDX_W    = 3
) (
  input  logic [NUM_REFS-1:0]       qual_i,
  input  logic [NUM_REFS*IDX_W-1:0] prio_tbl_i,
  input  logic                      manual_en_i,
  input  logic [IDX_W-1:0]          manual_sel_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o
);
  localparam int QX = 1 << IDX_W;

  logic [QX-1:0]       qual_x;
  logic [IDX_W-1:0]    rank_idx [NUM_REFS];
  logic [NUM_REFS-1:0] rank_hit;

  assign qual_x = QX'(qual_i);

  for (genvar k = 0; k < NUM_REFS; k++) begin : g_rank
    assign rank_idx[k] = prio_tbl_i[k*IDX_W +: IDX_W];
    assign rank_hit[k] = qual_x[rank_idx[k]];
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '1;
    if (manual_en_i) begin
      if (qual_x[manual_sel_i]) begin
        found_o = 1'b1;
        idx_o   = manual_sel_i;
      end
    end else begin
      // lowest rank wins: scan from the bottom up
      for (int k = NUM_REFS - 1; k >= 0; k--) begin
        if (rank_hit[k]) begin
          found_o = 1'b1;
          idx_o   = rank_idx[k];
        end
      end
    end
  end
endmodule

// File: rtl/msref_soak.sv
module msref_soak #(
  parameter int SOAK_TICKS = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(SOAK_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SOAK_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (done_o)      cnt_q <= '0;
    else if (tick_i)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/msref_ind.sv
module msref_ind
  import msref_pkg::*;
#(
  parameter int NUM_REFS = 6,
  parameter int IDX_W    = 3
) (
  input  logic               slave_q_i,
  input  msref_state_e       state_i,
  input  logic [IDX_W-1:0]   sel_i,
  input  logic               lock_det_i,
  output logic [NUM_REFS-1:0] ref_ind_o,
  output logic               free_run_o,
  output logic               holdover_o,
  output logic               alarm_o,
  output logic               lock_o,
  output logic               wide_bw_o
);
  logic on_local, tracking;

  assign on_local = (state_i == ST_LOCAL);
  assign tracking = (state_i == ST_TRACK);

  for (genvar r = 0; r < NUM_REFS; r++) begin : g_ind
    assign ref_ind_o[r] = !slave_q_i && on_local && (sel_i == IDX_W'(r));
  end

  assign free_run_o = !slave_q_i && (state_i == ST_FREE);
  assign holdover_o = !slave_q_i && (state_i == ST_HOLD);
  assign wide_bw_o  = slave_q_i && tracking;

  always_comb begin
    if (slave_q_i) begin
      alarm_o = !tracking;
      lock_o  = tracking ? lock_det_i : 1'b1;
    end else begin
      alarm_o = !on_local;
      lock_o  = on_local && lock_det_i;
    end
  end
endmodule

// File: rtl/msref_ctrl.sv
module msref_ctrl
  import msref_pkg::*;
#(
  parameter int NUM_REFS   = 6,
  parameter int OFS_W      = 12,
  parameter int HOLD_PPM   = 125,
  parameter int SOAK_TICKS = 10000,
  parameter int STAT_W     = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              slave_mode_i,
  input  logic                              tick_i,
  input  logic                              mst_present_i,
  input  logic signed [OFS_W-1:0]           mst_offset_i,
  input  logic [NUM_REFS-1:0]               ref_qual_i,
  input  logic [NUM_REFS*$clog2(NUM_REFS+2)-1:0] prio_tbl_i,
  input  logic                              manual_en_i,
  input  logic [$clog2(NUM_REFS+2)-1:0]     manual_sel_i,
  input  logic                              lock_det_i,
  output logic [$clog2(NUM_REFS+2)-1:0]     ref_sel_o,
  output logic                              wide_bw_o,
  output logic [NUM_REFS-1:0]               ref_ind_o,
  output logic                              free_run_o,
  output logic                              holdover_o,
  output logic                              alarm_o,
  output logic                              lock_o,
  output logic [STAT_W-1:0]                 status_o
);
  localparam int IDX_W = $clog2(NUM_REFS + 2);
  localparam logic [IDX_W-1:0] MST_IDX  = IDX_W'(NUM_REFS);
  localparam logic [IDX_W-1:0] NONE_IDX = '1;
  localparam int MAG_W = OFS_W + 1;

  msref_state_e      state_q, state_d;
  logic              slave_q;
  logic [IDX_W-1:0]  sel_q, sel_d;
  logic              had_lock_q;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              in_range, fallback_slave, soak_done;
  logic signed [MAG_W-1:0] ofs_ext, ofs_mag;

  assign ofs_ext  = MAG_W'(mst_offset_i);
  assign ofs_mag  = ofs_ext[MAG_W-1] ? -ofs_ext : ofs_ext;
  assign in_range = mst_present_i && (ofs_mag <= MAG_W'(HOLD_PPM));

  msref_prio_pick #(.NUM_REFS(NUM_REFS), .IDX_W(IDX_W)) u_pick (
    .qual_i      (ref_qual_i),
    .prio_tbl_i  (prio_tbl_i),
    .manual_en_i (manual_en_i),
    .manual_sel_i(manual_sel_i),
    .found_o     (pick_found),
    .idx_o       (pick_idx)
  );

  assign fallback_slave = slave_q && slave_mode_i && (state_q != ST_TRACK);

  msref_soak #(.SOAK_TICKS(SOAK_TICKS)) u_soak (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (fallback_slave && in_range),
    .tick_i(tick_i),
    .done_o(soak_done)
  );

  always_comb begin
    logic go_track;
    if (!slave_mode_i)                          go_track = 1'b0;
    else if (!slave_q || state_q == ST_TRACK)   go_track = in_range;
    else                                        go_track = soak_done;

    if (go_track) begin
      state_d = ST_TRACK;
      sel_d   = MST_IDX;
    end else if (pick_found) begin
      state_d = ST_LOCAL;
      sel_d   = pick_idx;
    end else begin
      state_d = had_lock_q ? ST_HOLD : ST_FREE;
      sel_d   = NONE_IDX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FREE;
      slave_q    <= 1'b0;
      sel_q      <= NONE_IDX;
      had_lock_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      slave_q    <= slave_mode_i;
      sel_q      <= sel_d;
      had_lock_q <= had_lock_q ||
                    (lock_det_i && (state_q == ST_LOCAL || state_q == ST_TRACK));
    end
  end

  msref_ind #(.NUM_REFS(NUM_REFS), .IDX_W(IDX_W)) u_ind (
    .slave_q_i (slave_q),
    .state_i   (state_q),
    .sel_i     (sel_q),
    .lock_det_i(lock_det_i),
    .ref_ind_o (ref_ind_o),
    .free_run_o(free_run_o),
    .holdover_o(holdover_o),
    .alarm_o   (alarm_o),
    .lock_o    (lock_o),
    .wide_bw_o (wide_bw_o)
  );

  assign ref_sel_o = sel_q;
  assign status_o  = STAT_W'({sel_q, state_q, slave_q});
endmodule

// File: rtl/msref_ctrl_chk.sv
module msref_ctrl_chk #(
  parameter int NUM_REFS = 6,
  parameter int OFS_W    = 12,
  parameter int HOLD_PPM = 125,
  parameter int STAT_W   = 8,
  parameter int IDX_W    = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    slave_mode_i,
  input logic                    mst_present_i,
  input logic signed [OFS_W-1:0] mst_offset_i,
  input logic                    lock_det_i,
  input logic [IDX_W-1:0]        ref_sel_o,
  input logic                    wide_bw_o,
  input logic [NUM_REFS-1:0]     ref_ind_o,
  input logic                    free_run_o,
  input logic                    holdover_o,
  input logic                    alarm_o,
  input logic                    lock_o,
  input logic [STAT_W-1:0]       status_o
);
  logic          is_slave, is_track, ok_range;
  int            mag;

  assign is_slave = status_o[0];
  assign is_track = (status_o[2:1] == 2'd0);
  assign mag      = (int'(mst_offset_i) < 0) ? -int'(mst_offset_i) : int'(mst_offset_i);
  assign ok_range = mst_present_i && (mag <= HOLD_PPM);

  AST_SLAVE_IND_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_slave |-> (ref_ind_o == '0 && !free_run_o && !holdover_o)); // R8

  AST_TRACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && is_track) |-> (!alarm_o && wide_bw_o && lock_o == lock_det_i)); // R9

  AST_FALLBACK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && !is_track) |-> (alarm_o && lock_o)); // R9

  AST_HOLD_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && is_track && slave_mode_i && ok_range) |=> (status_o[2:1] == 2'd0)); // R6

  AST_SOAK_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && !is_track && !ok_range) |=> (status_o[2:1] != 2'd0)); // R7

  AST_IND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ref_ind_o)); // R10

  AST_MASTER_NO_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_slave |-> (!is_track && ref_sel_o != IDX_W'(NUM_REFS))); // R2

  AST_STATUS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5:3] == ref_sel_o); // R11
endmodule

bind msref_ctrl msref_ctrl_chk #(
  .NUM_REFS(NUM_REFS), .OFS_W(OFS_W), .HOLD_PPM(HOLD_PPM),
  .STAT_W(STAT_W), .IDX_W($clog2(NUM_REFS+2))
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slave_mode_i(slave_mode_i),
  .mst_present_i(mst_present_i), .mst_offset_i(mst_offset_i),
  .lock_det_i(lock_det_i), .ref_sel_o(ref_sel_o), .wide_bw_o(wide_bw_o),
  .ref_ind_o(ref_ind_o), .free_run_o(free_run_o), .holdover_o(holdover_o),
  .alarm_o(alarm_o), .lock_o(lock_o), .status_o(status_o)
);

// File: tb/msref_ctrl_test.sv
module msref_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SOAK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_mode = 0, tick = 1, present = 0, manual_en = 0, lock_det = 0;
  logic signed [11:0] offset = '0;
  logic [5:0]  qual = '0;
  logic [17:0] prio;
  logic [2:0]  manual_sel = '0;
  logic [2:0]  ref_sel;
  logic        wide_bw, free_run, holdover, alarm, lock;
  logic [5:0]  ref_ind;
  logic [7:0]  status;

  int errors = 0, checks = 0;
  bit finished = 0;

  // rank0=2, rank1=0, rank2=5, rank3=1, rank4=3, rank5=4
  assign prio = {3'd4, 3'd3, 3'd1, 3'd5, 3'd0, 3'd2};

  always #(CLK_PERIOD/2) clk = ~clk;

  msref_ctrl #(.SOAK_TICKS(SOAK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave_mode), .tick_i(tick),
    .mst_present_i(present), .mst_offset_i(offset), .ref_qual_i(qual),
    .prio_tbl_i(prio), .manual_en_i(manual_en), .manual_sel_i(manual_sel),
    .lock_det_i(lock_det), .ref_sel_o(ref_sel), .wide_bw_o(wide_bw),
    .ref_ind_o(ref_ind), .free_run_o(free_run), .holdover_o(holdover),
    .alarm_o(alarm), .lock_o(lock), .status_o(status)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: state 0 track,1 local,2 hold,3 free; sel -1 encoded as 7
  int m_state, m_sel, m_cnt;
  bit m_mode, m_had;

  function automatic int pick();
    int ranks[6] = '{2, 0, 5, 1, 3, 4};
    if (manual_en) return (manual_sel < 6 && qual[manual_sel]) ? int'(manual_sel) : -1;
    foreach (ranks[k]) if (qual[ranks[k]]) return ranks[k];
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 3; m_sel = 7; m_cnt = 0; m_mode = 0; m_had = 0;
    end else begin
      bit rng, done, go;
      int p, n_state, n_sel;
      rng  = present && (int'(offset) >= -125) && (int'(offset) <= 125);
      done = 0;
      if (m_mode && slave_mode && m_state != 0 && rng) begin
        if (tick) begin
          if (m_cnt == SOAK - 1) begin done = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end else m_cnt = 0;
      if (!slave_mode) go = 0;
      else if (!m_mode || m_state == 0) go = rng;
      else go = done;
      p = pick();
      if (go) begin n_state = 0; n_sel = 6; end
      else if (p >= 0) begin n_state = 1; n_sel = p; end
      else begin n_state = m_had ? 2 : 3; n_sel = 7; end
      if (lock_det && (m_state == 0 || m_state == 1)) m_had = 1;
      m_state = n_state; m_sel = n_sel; m_mode = slave_mode;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_ind;
      e_ind = (!m_mode && m_state == 1) ? (1 << m_sel) : 0;
      chk(m_mode ? "R5" : "R2", "ref_sel", ref_sel, m_sel);
      chk("R11", "status", status, m_mode + (m_state << 1) + (m_sel << 3));
      chk(m_mode ? "R8" : "R10", "ref_ind", ref_ind, e_ind);
      chk(m_mode ? "R8" : "R10", "free_run", free_run, !m_mode && m_state == 3);
      chk(m_mode ? "R8" : "R10", "holdover", holdover, !m_mode && m_state == 2);
      chk("R5", "wide_bw", wide_bw, m_mode && m_state == 0);
      if (m_mode) begin
        chk("R9", "alarm", alarm, m_state != 0);
        chk("R9", "lock", lock, (m_state == 0) ? lock_det : 1);
      end else begin
        chk("R10", "alarm", alarm, m_state != 1);
        chk("R10", "lock", lock, m_state == 1 && lock_det);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(2);
    at_neg();
    chk("R1", "reset status", status, 8'h3E);
    chk("R1", "reset free_run", free_run, 1);
    chk("R1", "reset lock", lock, 0);
    rst_n = 1;
    cyc(2);
    // R4: nothing qualified, no lock ever -> free run
    at_neg(); chk("R4", "free run state", status[2:1], 3);
    // R2: master mode priority, master input ignored
    cyc(0); qual = 6'b111111; present = 1; offset = 12'sd5;
    cyc(2); chk("R2", "top rank", ref_sel, 2);
    qual = 6'b111011; cyc(2); chk("R2", "second rank", ref_sel, 0);
    present = 0; offset = 12'sd900; cyc(2); chk("R2", "master ignored", ref_sel, 0);
    lock_det = 1; cyc(2);
    // R4: lock seen -> holdover
    qual = '0; cyc(2); chk("R4", "holdover state", status[2:1], 2);
    chk("R10", "holdover pin", holdover, 1);
    // R3: manual
    manual_en = 1; manual_sel = 3'd4; qual = 6'b010001; cyc(2);
    chk("R3", "manual pick", ref_sel, 4);
    qual = 6'b000001; cyc(2); chk("R3", "manual unqualified", ref_sel, 7);
    manual_en = 0; qual = 6'b100000; cyc(2); chk("R2", "rank2", ref_sel, 5);
    // R5: enter slave with master in range
    present = 1; offset = 12'sd0; slave_mode = 1; cyc(1);
    chk("R5", "track sel", ref_sel, 6);
    chk("R5", "wide bw", wide_bw, 1);
    lock_det = 0; cyc(1); chk("R9", "lock follows", lock, 0);
    lock_det = 1;
    // R6: hold-in boundary
    offset = 12'sd125; cyc(3); chk("R6", "at +125", ref_sel, 6);
    offset = -12'sd125; cyc(3); chk("R6", "at -125", ref_sel, 6);
    offset = 12'sd126; cyc(1); chk("R6", "beyond 126", ref_sel, 5);
    chk("R9", "fallback alarm", alarm, 1);
    chk("R8", "slave ind low", ref_ind, 0);
    // R7: soak with restart
    offset = 12'sd10; cyc(5);
    present = 0; cyc(1); present = 1;
    cyc(SOAK - 1); chk("R7", "one before soak end", ref_sel, 5);
    cyc(1); chk("R7", "soak end", ref_sel, 6);
    // master lost -> local, holdover when none
    present = 0; cyc(1); chk("R6", "master lost", ref_sel, 5);
    qual = '0; cyc(1); chk("R8", "slave holdover pin", holdover, 0);
    chk("R11", "slave holdover status", status, 8'h3D);
    // R7: tick gated soak
    qual = 6'b000010; present = 1; tick = 0; cyc(SOAK + 2);
    chk("R7", "no tick no return", ref_sel, 1);
    tick = 1; cyc(SOAK); chk("R7", "tick return", ref_sel, 6);
    // back to master
    slave_mode = 0; cyc(1); chk("R2", "back to master", ref_sel, 1);
    chk("R10", "ind onehot", ref_ind, 6'b000010);
    cyc(3);
    finish_run();
  end
endmodule